// File: doc/BRIEF.md
# Block Address Translation Array

This unit translates an effective address into a 36-bit physical address for large, naturally aligned memory regions without touching any page table. It holds two banks of programmable translation entries, one consulted for instruction fetches and one for data accesses. Each entry is a pair of 32-bit words, an upper word that describes the effective region and a lower word that describes the physical target. Software loads a whole pair in one write cycle.

On every access cycle the unit compares the effective address against every entry of the selected bank in parallel. It applies a validity check that depends on the privilege level and picks the lowest-numbered matching entry. It then reports one registered verdict: hit (with the physical address and cache attributes), miss, or protection fault. Raising exceptions and walking page tables are the job of the surrounding logic.

Top module: `bat_xlate_top`

## Requirements
- R1: After reset every entry of both banks is invalid, so hit, miss and protFault are low while idle and the first access reports a miss.
- R2: An entry matches when effective address bits 31:17, with the bits selected by the block-length field cleared, equal upper-word bits 31:17 under the same clearing. The block-length field is upper-word bits 12:2, and its bit 0 lines up with effective address bit 17.
- R3: A block-length field of all zeros covers 128 KB, and each further contiguous one starting from bit 0 doubles the region. A mask of 3 ones covers 1 MB. An address one byte past the region does not match.
- R4: An entry counts as valid only for the current privilege. Upper-word bit 1 enables it in supervisor mode (accSuper=1) and upper-word bit 0 enables it in user mode (accSuper=0).
- R5: On a hit, paddr[31:17] is lower-word bits 31:17 OR-ed with the effective bits selected by the block-length field, and paddr[16:0] is the effective address bits 16:0. paddr[35:33] comes from lower-word bits 11:9 and paddr[32] from lower-word bit 2.
- R6: On a hit, attr[3:0] gives write-through, cache-inhibit, coherence and guarded, taken from lower-word bits 6, 5, 4 and 3. On a miss or fault, attr and paddr are zero.
- R7: The permission field is lower-word bits 1:0. 00 denies every access, 01 and 11 allow reads only, 10 allows reads and writes.
- R8: A denied access raises protFault alone, with hit and miss low. At most one of hit, miss and protFault is high in any cycle.
- R9: When several entries of a bank match, the lowest-numbered one decides the result, including its permission.
- R10: accFetch=1 selects the instruction bank and accFetch=0 the data bank. A fetch is always checked as a read, whatever accWrite is. The guarded bit is stored as zero in instruction entries.
- R11: A valid access that matches no entry reports miss one cycle later.
- R12: Results are registered and appear in the cycle after the access. With accValid low, all three verdict outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write an entry pair this cycle |
| wrData | input | 1 | 1 = data bank, 0 = instruction bank for the write |
| wrIdx | input | IDXW | Entry number written |
| wrUpper | input | 32 | Upper word: region index, block length, valid bits |
| wrLower | input | 32 | Lower word: physical index, extension bits, attributes, permission |
| accValid | input | 1 | Access presented this cycle |
| accFetch | input | 1 | Access is an instruction fetch |
| accWrite | input | 1 | Access is a store |
| accSuper | input | 1 | Access made in supervisor mode |
| accEa | input | 32 | Effective address |
| hit | output | 1 | Translation succeeded (registered) |
| miss | output | 1 | No entry matched (registered) |
| protFault | output | 1 | Matching entry denied the access (registered) |
| paddr | output | 36 | Translated physical address |
| attr | output | 4 | {write-through, inhibit, coherence, guarded} |

## Verification
The hardest case to reach from the ports is an entry that is matched but shadowed: a higher-numbered entry with a stricter permission sits under a lower-numbered one covering the same region. Its verdict never shows until the winner is gone. The stimulus loads two overlapping data entries and confirms that a store through the lower-numbered entry succeeds. It then rewrites that entry as invalid and repeats the access, which must now fault on the uncovered entry. A second hidden case is the guarded bit being dropped on instruction writes. It is only visible through a fetch hit whose attr output must show guarded clear although the written lower word had it set.

// File: rtl/bat_pkg.sv
package bat_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEntry;
    logic wrData;
    logic hit;
    logic miss;
    logic fault;
  } batStrobe_t;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b10,
    PERM_RO_B = 2'b11
  } batPerm_t;

  localparam int EA_W  = 32;
  localparam int PA_W  = 36;
  localparam int BLK_LSB = 17;
endpackage

// File: rtl/bat_datapath.sv
module bat_datapath
  import bat_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  batStrobe_t         str,
  input  logic [IDXW-1:0]    wrIdx,
  input  logic [31:0]        wrUpper,
  input  logic [31:0]        wrLower,
  input  logic               accFetch,
  input  logic               accSuper,
  input  logic [EA_W-1:0]    accEa,
  input  logic [IDXW-1:0]    winIdx,
  output logic [ENTRIES-1:0] matchVec,
  output logic [1:0]         winPerm,
  output logic               hitQ,
  output logic               missQ,
  output logic               faultQ,
  output logic [PA_W-1:0]    paddrQ,
  output logic [3:0]         attrQ
);
  localparam int IDX_BITS = EA_W - BLK_LSB;   // 15
  localparam int BL_BITS  = 11;

  logic [31:0] upInst [ENTRIES];
  logic [31:0] loInst [ENTRIES];
  logic [31:0] upData [ENTRIES];
  logic [31:0] loData [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        upInst[i] <= '0;
        loInst[i] <= '0;
        upData[i] <= '0;
        loData[i] <= '0;
      end
    end else if (str.wrEntry) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wrIdx == IDXW'(i)) begin
          if (str.wrData) begin
            upData[i] <= wrUpper;
            loData[i] <= wrLower;
          end else begin
            upInst[i] <= wrUpper;
            loInst[i] <= wrLower & ~32'h0000_0008;  // guarded held at zero
          end
        end
      end
    end
  end

  // parallel compare over the selected bank
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    logic [31:0]         upSel;
    logic [IDX_BITS-1:0] blMask;
    logic                entValid;
    assign upSel    = accFetch ? upInst[g] : upData[g];
    assign blMask   = {{(IDX_BITS-BL_BITS){1'b0}}, upSel[12:2]};
    assign entValid = accSuper ? upSel[1] : upSel[0];
    assign matchVec[g] = entValid &&
      (((accEa[EA_W-1:BLK_LSB] ^ upSel[31:BLK_LSB]) & ~blMask) == '0);
  end

  logic [31:0]         upWin, loWin;
  logic [IDX_BITS-1:0] winMask;
  logic [PA_W-1:0]     paNext;

  assign upWin   = accFetch ? upInst[winIdx] : upData[winIdx];
  assign loWin   = accFetch ? loInst[winIdx] : loData[winIdx];
  assign winPerm = loWin[1:0];
  assign winMask = {{(IDX_BITS-BL_BITS){1'b0}}, upWin[12:2]};
  assign paNext  = {loWin[11:9], loWin[2],
                    loWin[31:BLK_LSB] | (accEa[EA_W-1:BLK_LSB] & winMask),
                    accEa[BLK_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ   <= 1'b0;
      missQ  <= 1'b0;
      faultQ <= 1'b0;
      paddrQ <= '0;
      attrQ  <= '0;
    end else begin
      hitQ   <= str.hit;
      missQ  <= str.miss;
      faultQ <= str.fault;
      paddrQ <= str.hit ? paNext : '0;
      attrQ  <= str.hit ? loWin[6:3] : '0;
    end
  end
endmodule

// File: rtl/bat_control.sv
module bat_control
  import bat_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               wrEn,
  input  logic               wrData,
  input  logic               accValid,
  input  logic               accFetch,
  input  logic               accWrite,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [1:0]         winPerm,
  output logic [IDXW-1:0]    winIdx,
  output batStrobe_t         str
);
  logic anyMatch;
  logic isStore;
  logic denied;

  // lowest index has priority
  always_comb begin
    winIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) winIdx = IDXW'(i);
    end
  end

  assign anyMatch = |matchVec;
  assign isStore  = accWrite && !accFetch;

  always_comb begin
    unique case (batPerm_t'(winPerm))
      PERM_NONE: denied = 1'b1;
      PERM_RW:   denied = 1'b0;
      default:   denied = isStore;
    endcase
  end

  always_comb begin
    str.wrEntry = wrEn;
    str.wrData  = wrData;
    str.hit     = accValid && anyMatch && !denied;
    str.miss    = accValid && !anyMatch;
    str.fault   = accValid && anyMatch && denied;
  end
endmodule

// File: rtl/bat_xlate_top.sv
module bat_xlate_top
  import bat_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            wrData,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [31:0]     wrUpper,
  input  logic [31:0]     wrLower,
  input  logic            accValid,
  input  logic            accFetch,
  input  logic            accWrite,
  input  logic            accSuper,
  input  logic [31:0]     accEa,
  output logic            hit,
  output logic            miss,
  output logic            protFault,
  output logic [35:0]     paddr,
  output logic [3:0]      attr
);
  batStrobe_t         str;
  logic [ENTRIES-1:0] matchVec;
  logic [1:0]         winPerm;
  logic [IDXW-1:0]    winIdx;

  bat_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .accValid(accValid), .accFetch(accFetch),
    .accWrite(accWrite), .matchVec(matchVec), .winPerm(winPerm),
    .winIdx(winIdx), .str(str)
  );

  bat_datapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .wrIdx(wrIdx), .wrUpper(wrUpper),
    .wrLower(wrLower), .accFetch(accFetch), .accSuper(accSuper), .accEa(accEa),
    .winIdx(winIdx), .matchVec(matchVec), .winPerm(winPerm),
    .hitQ(hit), .missQ(miss), .faultQ(protFault), .paddrQ(paddr), .attrQ(attr)
  );
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic        accFetch,
  input logic [31:0] accEa,
  input logic        hit,
  input logic        miss,
  input logic        protFault,
  input logic [35:0] paddr,
  input logic [3:0]  attr
);
  p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({hit, miss, protFault}) <= 1);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !(hit || miss || protFault));

  p_access_answered_r11: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> (hit || miss || protFault));

  p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> (!hit || paddr[16:0] == $past(accEa[16:0])));

  p_fetch_unguarded_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accFetch) |=> !attr[0]);

  p_nohit_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (paddr == '0 && attr == '0));
endmodule

bind bat_xlate_top bat_xlate_chk u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accFetch(accFetch),
  .accEa(accEa), .hit(hit), .miss(miss), .protFault(protFault),
  .paddr(paddr), .attr(attr)
);

// File: tb/test_bat_xlate_top.sv
module test_bat_xlate_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn, wrData;
  logic [1:0]  wrIdx;
  logic [31:0] wrUpper, wrLower;
  logic        accValid, accFetch, accWrite, accSuper;
  logic [31:0] accEa;
  logic        hit, miss, protFault;
  logic [35:0] paddr;
  logic [3:0]  attr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  bat_xlate_top #(.ENTRIES(4)) i_bat_xlate_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrIdx(wrIdx),
    .wrUpper(wrUpper), .wrLower(wrLower), .accValid(accValid),
    .accFetch(accFetch), .accWrite(accWrite), .accSuper(accSuper),
    .accEa(accEa), .hit(hit), .miss(miss), .protFault(protFault),
    .paddr(paddr), .attr(attr)
  );

  typedef struct packed {
    logic        fetch;
    logic        wr;
    logic        sup;
    logic [31:0] ea;
    logic [2:0]  verdict;  // {hit, miss, fault}
    logic [35:0] pa;
    logic [3:0]  at;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b0,1'b1,32'h100A_1234,3'b100,36'hB_800A_1234,4'h9,4'd5},  // R2 R5 R6
    '{1'b0,1'b0,1'b0,32'h100F_FFFF,3'b100,36'hB_800F_FFFF,4'h9,4'd3},  // R3 top of 1MB
    '{1'b0,1'b0,1'b1,32'h1010_0000,3'b010,36'h0,4'h0,4'd3},            // R3 past 1MB
    '{1'b0,1'b0,1'b1,32'h2000_0010,3'b010,36'h0,4'h0,4'd4},            // R4 user-only
    '{1'b0,1'b0,1'b0,32'h2000_0010,3'b100,36'h0_0040_0010,4'h4,4'd4},  // R4
    '{1'b0,1'b1,1'b0,32'h2000_0010,3'b001,36'h0,4'h0,4'd8},            // R7 R8 store to RO
    '{1'b0,1'b0,1'b0,32'h2002_0000,3'b010,36'h0,4'h0,4'd3},            // R3 past 128KB
    '{1'b0,1'b0,1'b1,32'h4000_0008,3'b100,36'h0_0060_0008,4'h0,4'd7},  // R7 perm 11 reads
    '{1'b0,1'b1,1'b1,32'h4000_0008,3'b001,36'h0,4'h0,4'd7},            // R7 perm 11 store
    '{1'b0,1'b0,1'b0,32'h4000_0008,3'b010,36'h0,4'h0,4'd4},            // R4 supervisor-only
    '{1'b0,1'b1,1'b1,32'h1000_0100,3'b100,36'hB_8000_0100,4'h9,4'd9},  // R9 entry 0 wins
    '{1'b1,1'b0,1'b1,32'h1000_0040,3'b100,36'h0_00C0_0040,4'h2,4'd10}, // R10 guarded dropped
    '{1'b1,1'b1,1'b1,32'h1000_0040,3'b100,36'h0_00C0_0040,4'h2,4'd10}, // R10 fetch as read
    '{1'b1,1'b0,1'b0,32'h100A_1234,3'b010,36'h0,4'h0,4'd10}            // R10 bank apart
  };

  task automatic checkOut(string tag, logic [2:0] expV, logic [35:0] expPa,
                          logic [3:0] expAt);
    checks++;
    if ({hit, miss, protFault} !== expV || paddr !== expPa || attr !== expAt) begin
      errors++;
      $display("FAIL %s: got v=%b pa=%h at=%h expected v=%b pa=%h at=%h",
               tag, {hit, miss, protFault}, paddr, attr, expV, expPa, expAt);
    end
  endtask

  task automatic writePair(logic side, logic [1:0] idx, logic [31:0] up,
                           logic [31:0] lo);
    @(negedge clk);
    wrEn = 1'b1; wrData = side; wrIdx = idx; wrUpper = up; wrLower = lo;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic access(logic f, logic w, logic s, logic [31:0] ea);
    @(negedge clk);
    accValid = 1'b1; accFetch = f; accWrite = w; accSuper = s; accEa = ea;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = 1'b0; wrIdx = '0; wrUpper = '0;
    wrLower = '0; accValid = 1'b0; accFetch = 1'b0; accWrite = 1'b0;
    accSuper = 1'b0; accEa = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 idle after reset", 3'b000, 36'h0, 4'h0);
    access(1'b0, 1'b0, 1'b1, 32'h1000_0000);
    checkOut("R1 empty bank misses", 3'b010, 36'h0, 4'h0);
    access(1'b1, 1'b0, 1'b0, 32'h0000_0000);
    checkOut("R11 empty instruction bank", 3'b010, 36'h0, 4'h0);

    // data bank
    writePair(1'b1, 2'd0, 32'h1000_001F, 32'h8000_0A4E); // 1MB, RW, W+G, ext 1011
    writePair(1'b1, 2'd1, 32'h2000_0001, 32'h0040_0021); // user only, RO, I
    writePair(1'b1, 2'd2, 32'h4000_0002, 32'h0060_0003); // super only, perm 11
    writePair(1'b1, 2'd3, 32'h1000_0003, 32'h0000_0000); // overlaps 0, no access
    // instruction bank
    writePair(1'b0, 2'd0, 32'h1000_0003, 32'h00C0_0019); // M+G, RO

    @(negedge clk);
    checkOut("R12 no access no verdict", 3'b000, 36'h0, 4'h0);

    for (int k = 0; k < NVEC; k++) begin
      access(VEC[k].fetch, VEC[k].wr, VEC[k].sup, VEC[k].ea);
      checkOut($sformatf("R%0d vector %0d", VEC[k].req, k),
               VEC[k].verdict, VEC[k].pa, VEC[k].at);
    end

    // R9: remove entry 0, the shadowed no-access entry 3 now decides
    writePair(1'b1, 2'd0, 32'h0000_0000, 32'h0000_0000);
    access(1'b0, 1'b0, 1'b1, 32'h1000_0100);
    checkOut("R9 shadowed entry exposed, R7 perm 00 faults read", 3'b001, 36'h0, 4'h0);
    access(1'b0, 1'b0, 1'b1, 32'h100A_1234);
    checkOut("R11 removed region misses", 3'b010, 36'h0, 4'h0);
    access(1'b1, 1'b0, 1'b1, 32'h1000_0040);
    checkOut("R10 instruction bank untouched", 3'b100, 36'h0_00C0_0040, 4'h2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule